// File: doc/BRIEF.md
# Pipelined Streaming Vector Adder

This block adds two integer vectors held in a word-addressed memory and writes the element-wise sums to a third area of that memory. A single-cycle `start` pulse supplies three base addresses and an element count. The block then drives two read ports and one write port of a synchronous memory. Each read port returns data one cycle after the request, and the write port takes one word per cycle without stalling.

Address stepping, the two operand fetches, the addition and the store-back all run at the same time for different elements. After a fixed fill of four cycles, one sum is stored on every clock. Each address register is loaded once from its base and then increments by one per access. Additions are two's-complement and wrap. Only one vector operation is in flight at a time.

Top module: `vec_add_stream`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done`, `rd_x_en`, `rd_z_en` and `wr_en` are all low.
- R2: Take cycle 1 as the cycle after the clock edge that samples an accepted `start`. The first x read is issued in cycle 2, the first z read in cycle 3, and the first write in cycle 5.
- R3: The k-th x read (k counted from 0) uses address `x_base+k`, the k-th z read uses `z_base+k`, and the k-th write uses `y_base+k`.
- R4: Each written word equals x(k)+z(k) modulo 2^DATA_W. No overflow is signalled, so all-ones plus one stores zero.
- R5: A run of effective length L issues exactly L writes on L consecutive cycles (cycles 5 to L+4).
- R6: `done` is high for exactly one cycle, the cycle after the last write (cycle L+5). `busy` is high from cycle 1 through the cycle of the last write and is low while `done` is high.
- R7: A `start` with `len`=0 causes no reads and no writes, raises `done` in cycle 1, and leaves `busy` low.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The running operation keeps its addresses, its length and its results.
- R9: A `len` above MAX_LEN is treated as MAX_LEN.
- R10: Each run issues exactly L x reads and L z reads, and every z read comes in the cycle directly after an x read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a vector add (ignored while busy) |
| x_base | input | ADDR_W | First address of operand vector x |
| z_base | input | ADDR_W | First address of operand vector z |
| y_base | input | ADDR_W | First address of result vector y |
| len | input | $clog2(MAX_LEN+1) | Element count, 0 to MAX_LEN |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_x_en | output | 1 | Read request, x port |
| rd_x_addr | output | ADDR_W | Read address, x port |
| rd_x_data | input | DATA_W | Read data for x, one cycle after the request |
| rd_z_en | output | 1 | Read request, z port |
| rd_z_addr | output | ADDR_W | Read address, z port |
| rd_z_data | input | DATA_W | Read data for z, one cycle after the request |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Sum to write |

## Verification
The bench builds the block with DATA_W=64, MAX_LEN=128 and ADDR_W narrowed to 10, which allows a 1024-word model memory. With those values the bench can run the full 128-element vector, the clamp of an oversized length (200) down to 128, the wrap of 64-bit sums, a single-element run and a zero-length run. A second `start` injected during a run, carrying different bases and length, shows that the running operation is unaffected.

// File: rtl/vec_add_stream.sv
module vec_add_stream #(
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 32,
  parameter int MAX_LEN = 128,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] x_base,
  input  logic [ADDR_W-1:0] z_base,
  input  logic [ADDR_W-1:0] y_base,
  input  logic [LEN_W-1:0]  len,
  output logic              busy,
  output logic              done,
  output logic              rd_x_en,
  output logic [ADDR_W-1:0] rd_x_addr,
  input  logic [DATA_W-1:0] rd_x_data,
  output logic              rd_z_en,
  output logic [ADDR_W-1:0] rd_z_addr,
  input  logic [DATA_W-1:0] rd_z_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);

  logic [1:0]        phase;
  logic [LEN_W-1:0]  x_left, z_left, w_left;
  logic [ADDR_W-1:0] x_ptr, z_ptr, y_ptr;
  logic              x_back, z_back, sum_vld;
  logic [DATA_W-1:0] x_hold, sum_q;
  logic [LEN_W-1:0]  eff_len;

  assign eff_len   = (len > LEN_CAP) ? LEN_CAP : len;
  assign rd_x_en   = busy && (phase != 2'd0) && (x_left != '0);
  assign rd_z_en   = busy && (phase == 2'd2) && (z_left != '0);
  assign rd_x_addr = x_ptr;
  assign rd_z_addr = z_ptr;
  assign wr_en     = sum_vld;
  assign wr_addr   = y_ptr;
  assign wr_data   = sum_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      phase   <= 2'd0;
      x_left  <= '0;
      z_left  <= '0;
      w_left  <= '0;
      x_ptr   <= '0;
      z_ptr   <= '0;
      y_ptr   <= '0;
      x_back  <= 1'b0;
      z_back  <= 1'b0;
      sum_vld <= 1'b0;
      x_hold  <= '0;
      sum_q   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (eff_len == '0) begin
            done <= 1'b1;
          end else begin
            busy   <= 1'b1;
            phase  <= 2'd0;
            x_left <= eff_len;
            z_left <= eff_len;
            w_left <= eff_len;
            x_ptr  <= x_base;
            z_ptr  <= z_base;
            y_ptr  <= y_base;
          end
        end
      end else begin
        if (phase != 2'd2) phase <= phase + 2'd1;
        if (rd_x_en) begin
          x_ptr  <= x_ptr + 1'b1;
          x_left <= x_left - 1'b1;
        end
        if (rd_z_en) begin
          z_ptr  <= z_ptr + 1'b1;
          z_left <= z_left - 1'b1;
        end
        if (wr_en) begin
          y_ptr  <= y_ptr + 1'b1;
          w_left <= w_left - 1'b1;
          if (w_left == LEN_W'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
      x_back  <= rd_x_en;
      z_back  <= rd_z_en;
      sum_vld <= z_back;
      if (x_back) x_hold <= rd_x_data;
      if (z_back) sum_q  <= x_hold + rd_z_data;
    end
  end

endmodule

// File: rtl/vec_add_stream_chk.sv
module vec_add_stream_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              rd_x_en,
  input logic [ADDR_W-1:0] rd_x_addr,
  input logic              rd_z_en,
  input logic [ADDR_W-1:0] rd_z_addr,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr
);

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r6_done_after_last_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_en) |-> done);

  a_r6_write_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  a_r10_z_follows_x: assert property (@(posedge clk) disable iff (!rst_n)
    rd_z_en |-> $past(rd_x_en));

  a_r3_x_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_x_en && $past(rd_x_en)) |-> rd_x_addr == $past(rd_x_addr) + 1'b1);

  a_r3_z_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_z_en && $past(rd_z_en)) |-> rd_z_addr == $past(rd_z_addr) + 1'b1);

  a_r3_y_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> wr_addr == $past(wr_addr) + 1'b1);

  a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wr_en) && busy) |-> 1'b0);

endmodule

bind vec_add_stream vec_add_stream_chk #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .rd_x_en(rd_x_en), .rd_x_addr(rd_x_addr),
  .rd_z_en(rd_z_en), .rd_z_addr(rd_z_addr),
  .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/vec_add_stream_test.sv
`timescale 1ns/1ps
module vec_add_stream_test;
  localparam int DW = 64;
  localparam int AW = 10;
  localparam int ML = 128;
  localparam int LW = $clog2(ML + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] x_base = '0, z_base = '0, y_base = '0;
  logic [LW-1:0] len = '0;
  logic busy, done, rd_x_en, rd_z_en, wr_en;
  logic [AW-1:0] rd_x_addr, rd_z_addr, wr_addr;
  logic [DW-1:0] rd_x_data, rd_z_data, wr_data;

  logic [DW-1:0] mem [1024];
  logic [AW-1:0] exp_addr [$];
  logic [DW-1:0] exp_data [$];
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  vec_add_stream #(.DATA_W(DW), .ADDR_W(AW), .MAX_LEN(ML)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .x_base(x_base), .z_base(z_base), .y_base(y_base), .len(len),
    .busy(busy), .done(done),
    .rd_x_en(rd_x_en), .rd_x_addr(rd_x_addr), .rd_x_data(rd_x_data),
    .rd_z_en(rd_z_en), .rd_z_addr(rd_z_addr), .rd_z_data(rd_z_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  always @(posedge clk) begin
    if (rd_x_en) rd_x_data <= mem[rd_x_addr];
    if (rd_z_en) rd_z_data <= mem[rd_z_addr];
    if (wr_en)   mem[wr_addr] <= wr_data;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every write is matched against the expected queue (R3, R4, R8)
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (exp_addr.size() == 0) begin
        check(1'b0, "R5 unexpected write", {54'd0, wr_addr}, 64'd0);
      end else begin
        logic [AW-1:0] ea;
        logic [DW-1:0] ed;
        ea = exp_addr.pop_front();
        ed = exp_data.pop_front();
        check(wr_addr == ea, "R3 write address", {54'd0, wr_addr}, {54'd0, ea});
        check(wr_data == ed, "R4 write data", wr_data, ed);
      end
    end
  end

  task automatic run(input int xb, input int zb, input int yb, input int ln, input bit inject);
    int el, n, fx, fz, fw, lw, nx, nz, nw, dn, bad_busy;
    el = (ln > ML) ? ML : ln;
    for (int k = 0; k < el; k++) begin
      exp_addr.push_back(AW'(yb + k));
      exp_data.push_back(mem[xb + k] + mem[zb + k]);
    end
    @(negedge clk);
    start = 1'b1; x_base = AW'(xb); z_base = AW'(zb); y_base = AW'(yb); len = LW'(ln);
    @(negedge clk);
    start = 1'b0;
    n = 1; fx = 0; fz = 0; fw = 0; lw = 0; nx = 0; nz = 0; nw = 0; dn = 0; bad_busy = 0;
    while (n < 400) begin
      if (rd_x_en) begin nx++; if (fx == 0) fx = n; end
      if (rd_z_en) begin nz++; if (fz == 0) fz = n; end
      if (wr_en) begin nw++; if (fw == 0) fw = n; lw = n; end
      if (el > 0 && n <= el + 4 && !busy) bad_busy++;
      if (done) begin dn = n; if (busy) bad_busy++; break; end
      if (inject && n == 3) begin
        start = 1'b1; x_base = 10'd900; z_base = 10'd910; y_base = 10'd920; len = LW'(2);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    if (el == 0) begin
      check(dn == 1, "R7 done cycle", 64'(dn), 64'd1);
      check(nw == 0 && nx == 0 && nz == 0, "R7 no memory access", 64'(nw + nx + nz), 64'd0);
      check(!busy, "R7 busy low", {63'd0, busy}, 64'd0);
    end else begin
      check(fx == 2, "R2 first x read cycle", 64'(fx), 64'd2);
      check(fz == 3, "R2 first z read cycle", 64'(fz), 64'd3);
      check(fw == 5, "R2 first write cycle", 64'(fw), 64'd5);
      check(nw == el, "R5 write count", 64'(nw), 64'(el));
      check(lw - fw + 1 == nw, "R5 consecutive writes", 64'(lw - fw + 1), 64'(nw));
      check(nx == el && nz == el, "R10 read counts", 64'(nx + nz), 64'(2 * el));
      check(dn == el + 5, "R6 done cycle", 64'(dn), 64'(el + 5));
      check(bad_busy == 0, "R6 busy window", 64'(bad_busy), 64'd0);
      if (ln > ML) check(nw == ML, "R9 clamped length", 64'(nw), 64'(ML));
      if (inject) check(nw == el && exp_addr.size() == 0, "R8 start ignored while busy", 64'(nw), 64'(el));
    end
    check(exp_addr.size() == 0, "R5 all expected writes seen", 64'(exp_addr.size()), 64'd0);
    @(negedge clk);
    check(!done && !busy, "R6 done single cycle", {62'd0, done, busy}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 64'h9E3779B97F4A7C15 * 64'(i + 7) ^ 64'(i);
    repeat (3) @(negedge clk);
    check(!busy && !done && !rd_x_en && !rd_z_en && !wr_en, "R1 reset outputs",
          {59'd0, busy, done, rd_x_en, rd_z_en, wr_en}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !wr_en, "R1 after reset", {61'd0, busy, done, wr_en}, 64'd0);

    run(0, 256, 512, 1, 1'b0);
    run(10, 300, 600, 16, 1'b0);
    run(0, 256, 512, 128, 1'b0);
    for (int k = 0; k < 8; k++) begin
      mem[40 + k]  = 64'hFFFF_FFFF_FFFF_FFFF - 64'(k);
      mem[140 + k] = 64'(k + 1);
    end
    run(40, 140, 700, 8, 1'b0);  // R4: every sum wraps to zero
    check(mem[700] == 64'd0 && mem[707] == 64'd0, "R4 wrap to zero", mem[707], 64'd0);
    run(0, 0, 0, 0, 1'b0);
    run(5, 260, 530, 200, 1'b0);
    run(20, 280, 800, 12, 1'b1);
    run(3, 3, 3, 0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule